// File: doc/BRIEF.md
# Frame Check Sequence Appender and Checker

This unit sits on byte streams that carry framed link-layer traffic. It has two independent paths. The transmit path forwards payload bytes unchanged. It runs a 16-bit cyclic redundancy check over them, and after the byte flagged as the last of the frame it inserts two check bytes. The transmit path takes the generator x^16 + x^12 + x^5 + 1. The register starts at all ones, takes bits least significant first, and its inverted contents are sent low byte first. The receive path runs the same check over every byte of a frame, the two trailing check bytes included. At the end of the frame it reports whether the register landed on the fixed good-frame residue.

Both streams use valid/ready handshakes with a last marker, and a byte moves only in a cycle where valid and ready are both high. On transmit, payload passes straight through, so upstream sees downstream's ready while payload flows. While the two check bytes are pending, upstream is held off with ready low. A check byte stays on the output, unchanged, until downstream accepts it. The receive input never applies back-pressure. Flag delimiting, byte stuffing and retransmission belong to neighbouring blocks.

Top module: `fcs_frame_unit`

## Requirements
- R1: While no check byte is pending, each accepted transmit input byte appears on the transmit output in the same handshake, with the same value, and with the output last marker low.
- R2: After the transmit byte marked last is accepted, the output carries two more bytes. The first is bits 7:0 and the second bits 15:8 of the inverted CRC register. The register is preset to 0xFFFF and updated least significant bit first with the reflected generator 0x8408. The output last marker is high only on the second check byte.
- R3: Any payload length of one byte or more is accepted. The payload FF 03 C0 21 04 03 00 07 0D 03 06 is followed by D0 then 3A.
- R4: While a check byte is pending, transmit input ready is low. A check byte held by low output ready keeps its value until accepted, and no byte is lost or duplicated.
- R5: The CRC register is preset again after each frame, so back-to-back frames give the same check bytes as frames sent alone.
- R6: In the cycle after the receive byte marked last is accepted, the result-valid output is high for exactly one cycle. The good output is then high only if the register over all frame bytes equals 0xF0B8. The good output is low whenever result-valid is low.
- R7: A receive frame of fewer than two bytes is reported as bad.
- R8: Receive bytes count only in cycles with input valid high. Receive ready is always high, and idle cycles inside a frame do not alter the result.
- R9: After reset, no transmit output byte is valid, transmit input ready follows output ready, and result-valid and good are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Transmit payload byte valid |
| tx_in_ready | output | 1 | Transmit path can take a payload byte |
| tx_in_data | input | 8 | Transmit payload byte |
| tx_in_last | input | 1 | Final payload byte of the frame |
| tx_out_valid | output | 1 | Transmit output byte valid |
| tx_out_ready | input | 1 | Downstream takes the output byte |
| tx_out_data | output | 8 | Payload or check byte |
| tx_out_last | output | 1 | High on the second check byte |
| rx_in_valid | input | 1 | Receive byte valid |
| rx_in_ready | output | 1 | Always high |
| rx_in_data | input | 8 | Receive byte, check bytes included |
| rx_in_last | input | 1 | Final byte of the received frame |
| rx_done | output | 1 | One-cycle result strobe |
| rx_good | output | 1 | Frame passed the check, valid with rx_done |

## Verification
The bench builds the unit with its default parameters: a 16-bit register, 8-bit bytes, the reflected generator 0x8408, preset 0xFFFF and residue 0xF0B8. These defaults bring the published eleven-byte frame and its D0 3A trailer within reach. They also make it possible to check the two-byte 00 00 frame, the shortest frame that passes, and a one-byte frame that must fail. A periodic stall on transmit output ready, together with a second frame offered during the check bytes, exercises the hold and re-preset rules.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  parameter int CRC_W  = 16;
  parameter int BYTE_W = 8;

  typedef enum logic [1:0] {
    TX_BODY   = 2'd0,
    TX_CHK_LO = 2'd1,
    TX_CHK_HI = 2'd2
  } tx_phase_t;

  // One byte through the reflected divider, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_byte(
    input logic [CRC_W-1:0]  cur,
    input logic [BYTE_W-1:0] din,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] r;
    logic fb;
    r = cur;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ din[i];
      r  = r >> 1;
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_accum.sv
module fcs_accum
  import fcs_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY   = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              init,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q,
  output logic [CRC_W-1:0]  crc_next
);
  assign crc_next = crc_byte(crc_q, din, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= PRESET;
    else if (init)  crc_q <= PRESET;
    else if (upd)   crc_q <= crc_next;
  end
endmodule

// File: rtl/fcs_tx_path.sv
module fcs_tx_path
  import fcs_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY   = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  localparam int NCHK = CRC_W / BYTE_W;

  tx_phase_t        phase_q, phase_d;
  logic [CRC_W-1:0] crc_q, crc_next, chk;
  logic             body_take, chk_take;

  assign chk       = ~crc_q;
  assign body_take = (phase_q == TX_BODY) && in_valid && out_ready;
  assign chk_take  = (phase_q != TX_BODY) && out_ready;

  fcs_accum #(.POLY(POLY), .PRESET(PRESET)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (body_take),
    .init     (chk_take && phase_q == TX_CHK_HI),
    .din      (in_data),
    .crc_q    (crc_q),
    .crc_next (crc_next)
  );

  always_comb begin
    phase_d   = phase_q;
    in_ready  = 1'b0;
    out_valid = 1'b1;
    out_last  = 1'b0;
    out_data  = in_data;
    case (phase_q)
      TX_BODY: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        if (body_take && in_last) phase_d = TX_CHK_LO;
      end
      TX_CHK_LO: begin
        out_data = chk[BYTE_W-1:0];
        if (out_ready) phase_d = TX_CHK_HI;
      end
      TX_CHK_HI: begin
        out_data = chk[NCHK*BYTE_W-1 -: BYTE_W];
        out_last = 1'b1;
        if (out_ready) phase_d = TX_BODY;
      end
      default: phase_d = TX_BODY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= TX_BODY;
    else        phase_q <= phase_d;
  end

  // R2: the first check byte follows the accepted last payload byte
  assert_chk_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> (out_valid && !out_last));

  // R4: no payload intake while a check byte is on the output
  assert_intake_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> !in_ready);

  // R4: a stalled check byte holds its value
  assert_chk_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != TX_BODY && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R2: the closing check byte ends the frame and intake reopens
  assert_last_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (phase_q == TX_BODY));

  logic unused_ok;
  assign unused_ok = ^crc_next;
endmodule

// File: rtl/fcs_rx_path.sv
module fcs_rx_path
  import fcs_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY    = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET  = 16'hFFFF,
  parameter logic [CRC_W-1:0] RESIDUE = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              done,
  output logic              good
);
  localparam int MIN_BYTES = CRC_W / BYTE_W;
  localparam int CNT_W     = $clog2(MIN_BYTES + 1);

  logic [CRC_W-1:0] crc_q, crc_next;
  logic [CNT_W-1:0] seen_q;
  logic             end_take, long_enough;

  assign in_ready    = 1'b1;
  assign end_take    = in_valid && in_last;
  // the closing byte itself counts toward the minimum
  assign long_enough = (int'(seen_q) + 1) >= MIN_BYTES;

  fcs_accum #(.POLY(POLY), .PRESET(PRESET)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (in_valid),
    .init     (end_take),
    .din      (in_data),
    .crc_q    (crc_q),
    .crc_next (crc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      done   <= 1'b0;
      good   <= 1'b0;
    end else begin
      done <= end_take;
      good <= end_take && long_enough && (crc_next == RESIDUE);
      if (end_take)
        seen_q <= '0;
      else if (in_valid && int'(seen_q) < MIN_BYTES)
        seen_q <= seen_q + 1'b1;
    end
  end

  // R6: the result strobe only follows an accepted closing byte
  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last));

  // R6: good is never shown outside the strobe
  assert_good_in_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    good |-> done);

  // R7: a frame made of its closing byte alone never passes
  assert_short_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(seen_q) == '0) |-> !good);

  logic unused_ok;
  assign unused_ok = ^crc_q;
endmodule

// File: rtl/fcs_frame_unit.sv
module fcs_frame_unit
  import fcs_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY    = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET  = 16'hFFFF,
  parameter logic [CRC_W-1:0] RESIDUE = 16'hF0B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [BYTE_W-1:0] tx_in_data,
  input  logic              tx_in_last,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [BYTE_W-1:0] tx_out_data,
  output logic              tx_out_last,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [BYTE_W-1:0] rx_in_data,
  input  logic              rx_in_last,
  output logic              rx_done,
  output logic              rx_good
);
  fcs_tx_path #(.POLY(POLY), .PRESET(PRESET)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_in_data),
    .in_last   (tx_in_last),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_data),
    .out_last  (tx_out_last)
  );

  fcs_rx_path #(.POLY(POLY), .PRESET(PRESET), .RESIDUE(RESIDUE)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_in_valid),
    .in_ready (rx_in_ready),
    .in_data  (rx_in_data),
    .in_last  (rx_in_last),
    .done     (rx_done),
    .good     (rx_good)
  );
endmodule

// File: tb/sim_fcs_frame_unit.sv
`timescale 1ns/1ps
module sim_fcs_frame_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_in_valid = 1'b0, tx_in_last = 1'b0, tx_out_ready = 1'b1;
  logic [7:0] tx_in_data = 8'h00;
  logic       tx_in_ready, tx_out_valid, tx_out_last;
  logic [7:0] tx_out_data;
  logic       rx_in_valid = 1'b0, rx_in_last = 1'b0;
  logic [7:0] rx_in_data = 8'h00;
  logic       rx_in_ready, rx_done, rx_good;

  int checks = 0, failures = 0;
  logic [7:0] cap_d [0:63];
  logic       cap_l [0:63];
  int         cap_n = 0;
  logic       bp_en = 1'b0;
  int         bp_cnt = 0;
  logic [7:0] ref_frame [0:10] = '{8'hFF,8'h03,8'hC0,8'h21,8'h04,8'h03,8'h00,8'h07,8'h0D,8'h03,8'h06};

  always #2.5 clk = ~clk;

  fcs_frame_unit u0 (.*);

  // record every output byte that completes a handshake at the next edge
  always @(negedge clk)
    if (rst_n && tx_out_valid && tx_out_ready && cap_n < 64) begin
      cap_d[cap_n] = tx_out_data; cap_l[cap_n] = tx_out_last; cap_n++;
    end

  always @(posedge clk) begin
    #1;
    bp_cnt++;
    tx_out_ready = bp_en ? (bp_cnt % 3 == 0) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r ^= 16'h8408;
    end
    return r;
  endfunction

  task automatic push_tx(input logic [7:0] b, input logic last);
    tx_in_valid = 1'b1; tx_in_data = b; tx_in_last = last;
    do @(negedge clk); while (!tx_in_ready);
    @(posedge clk); #1;
    tx_in_valid = 1'b0; tx_in_last = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b, input logic last);
    rx_in_valid = 1'b1; rx_in_data = b; rx_in_last = last;
    @(posedge clk); #1;
    rx_in_valid = 1'b0; rx_in_last = 1'b0; rx_in_data = 8'h5A;
  endtask

  task automatic wait_tx_drain();
    for (int i = 0; i < 60; i++) @(posedge clk);
    #1;
  endtask

  // compare captured bytes from base: n payload bytes then two check bytes
  task automatic check_stream(input int base, input logic [7:0] pl [0:15], input int n, input string tag);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = model_crc(c, pl[i]);
      check(cap_d[base+i] == pl[i] && !cap_l[base+i], {tag, " R1 payload"}, cap_d[base+i], pl[i]);
    end
    c = ~c;
    check(cap_d[base+n] == c[7:0] && !cap_l[base+n], {tag, " R2 check low"}, cap_d[base+n], c[7:0]);
    check(cap_d[base+n+1] == c[15:8] && cap_l[base+n+1], {tag, " R2 check high"}, cap_d[base+n+1], c[15:8]);
  endtask

  task automatic t_reset();
    #1;
    check(!tx_out_valid, "R9 tx_out_valid", tx_out_valid, 0);
    check(tx_in_ready == tx_out_ready, "R9 tx_in_ready", tx_in_ready, tx_out_ready);
    check(!rx_done && !rx_good, "R9 rx result", {rx_done, rx_good}, 0);
  endtask

  task automatic t_known_vector();
    logic [7:0] pl [0:15];
    for (int i = 0; i < 16; i++) pl[i] = (i < 11) ? ref_frame[i] : 8'h00;
    cap_n = 0;
    for (int i = 0; i < 11; i++) push_tx(pl[i], i == 10);
    wait_tx_drain();
    check(cap_n == 13, "R3 byte count", cap_n, 13);
    check(cap_d[11] == 8'hD0, "R3 check low D0", cap_d[11], 8'hD0);
    check(cap_d[12] == 8'h3A, "R3 check high 3A", cap_d[12], 8'h3A);
    check_stream(0, pl, 11, "vector");
  endtask

  task automatic t_stall_single();
    logic [7:0] pl [0:15];
    for (int i = 0; i < 16; i++) pl[i] = 8'h00;
    pl[0] = 8'h7E;
    cap_n = 0; bp_en = 1'b1;
    push_tx(pl[0], 1'b1);
    wait_tx_drain();
    bp_en = 1'b0;
    check(cap_n == 3, "R4 no loss or duplicate under stall", cap_n, 3);
    check_stream(0, pl, 1, "stall single R3");
  endtask

  task automatic t_back_to_back();
    logic [7:0] a [0:15];
    logic [7:0] b [0:15];
    for (int i = 0; i < 16; i++) begin a[i] = 8'h10 + 8'(i); b[i] = 8'hA0 ^ 8'(i); end
    cap_n = 0; bp_en = 1'b1;
    for (int i = 0; i < 4; i++) push_tx(a[i], i == 3);
    for (int i = 0; i < 3; i++) push_tx(b[i], i == 2);
    wait_tx_drain();
    bp_en = 1'b0;
    check(cap_n == 11, "R4 R5 stream length", cap_n, 11);
    check_stream(0, a, 4, "frame A R5");
    check_stream(6, b, 3, "frame B R5");
  endtask

  task automatic rx_frame(input logic [7:0] f [0:15], input int n, input bit gaps, input bit exp_good, input string tag);
    for (int i = 0; i < n; i++) begin
      if (gaps && i % 2 == 1) begin
        rx_in_data = 8'hC3; @(posedge clk); #1;
      end
      check(!rx_done, {tag, " R6 no early strobe"}, rx_done, 0);
      push_rx(f[i], i == n - 1);
    end
    @(negedge clk);
    check(rx_done, {tag, " R6 strobe"}, rx_done, 1);
    check(rx_good == exp_good, {tag, " R6 R7 verdict"}, rx_good, exp_good);
    @(negedge clk);
    check(!rx_done && !rx_good, {tag, " R6 one cycle"}, {rx_done, rx_good}, 0);
  endtask

  task automatic t_rx_cases();
    logic [7:0] f [0:15];
    check(rx_in_ready, "R8 rx ready high", rx_in_ready, 1);
    for (int i = 0; i < 16; i++) f[i] = (i < 11) ? ref_frame[i] : 8'h00;
    f[11] = 8'hD0; f[12] = 8'h3A;
    rx_frame(f, 13, 1'b0, 1'b1, "rx vector");
    rx_frame(f, 13, 1'b1, 1'b1, "rx gaps R8");
    f[4] = 8'h05;
    rx_frame(f, 13, 1'b0, 1'b0, "rx corrupted");
    f[0] = 8'h00; f[1] = 8'h00;
    rx_frame(f, 2, 1'b0, 1'b1, "rx two-byte minimum");
    f[0] = 8'hB8;
    rx_frame(f, 1, 1'b0, 1'b0, "rx one-byte R7");
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_known_vector();
    t_stall_single();
    t_back_to_back();
    t_rx_cases();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule